// File: doc/BRIEF.md
# Programmable Reloading Binary Up-Counter

An 8-bit synchronous binary up-counter. It can be preset from a parallel data input and chained into wider counters. An active-low terminal flag reports that the count is all ones while the stage is enabled from below. A mode input closes a feedback loop from that flag to the preset path. With the mode set, the counter reloads its preset at all ones instead of wrapping, so it works as a divide-by-(256 - preset) divider.

For a cascade, the terminal flag of each stage drives the cascade enable of the stage above. A single stage used as a divider takes its output from the registered divider pin, which pulses once on every reload. The divider pin is not meant for chaining. The master reset is asynchronous and active low. Everything else happens on the rising clock edge.

Top module: `reload_counter`

## Requirements
- R1: While `rst_ni` is low, and immediately after it falls even in the middle of a cycle, `count_o` is 0, `div_o` is 0 and `tc_no` is high.
- R2: When `load_i` is 1 at a rising edge, `count_o` takes `preset_i` on that edge. This holds whatever the enables and the mode are, and `div_o` is 0 in the following cycle.
- R3: With `load_i` at 0, the count advances only when both `cnt_en_ni` and `casc_en_ni` are 0. If either one is 1, `count_o` holds and `div_o` is 0 in the next cycle.
- R4: `tc_no` is 0 exactly when `count_o` is all ones (255) and `casc_en_ni` is 0. Otherwise it is 1. It follows `casc_en_ni` in the same cycle.
- R5: With `reload_mode_i` at 0 and the counter enabled, the count goes from 255 to 0 and keeps counting, and `div_o` stays 0.
- R6: With `reload_mode_i` at 1, `tc_no` at 0, both enables at 0 and `load_i` at 0, the next rising edge loads `preset_i`.
- R7: `div_o` is 1 for exactly the one cycle that follows each reload edge. With preset P in reload mode, rising edges of `div_o` are 256 - P cycles apart.
- R8: In a two-stage chain, the lower stage's `tc_no` drives the upper stage's `casc_en_ni`, and the upper stage's `cnt_en_ni` is held at 0. The pair then counts as one 16-bit value, {upper, lower}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| load_i | input | 1 | Parallel load of preset_i, highest priority |
| preset_i | input | 8 | Preset / reload value |
| cnt_en_ni | input | 1 | Count enable, active low |
| casc_en_ni | input | 1 | Cascade enable from the lower stage, active low |
| reload_mode_i | input | 1 | 1: reload at terminal count; 0: wrap |
| count_o | output | 8 | Current count |
| tc_no | output | 1 | Terminal count flag, active low, for chaining |
| div_o | output | 1 | Registered divider pulse, single-stage use only |

## Verification
`count_o` and `div_o` are due one rising edge after the inputs that cause them, and `tc_no` is due in the same cycle as `count_o` and `casc_en_ni`. The bench drives inputs 2 time units after a rising edge and steps a behavioural model on the next rising edge. At each falling edge it compares all three outputs with that model, so every result is read half a period after the edge that produced it. The asynchronous reset is checked 1 time unit after it falls, with no clock edge in between. Divide ratios are measured by counting the falling edges between successive rising edges of `div_o`.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_INC    = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_RELOAD = 2'd3
  } rc_act_e;
endpackage

// File: rtl/rc_term_detect.sv
module rc_term_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             casc_en_ni,
  output logic             term_o,
  output logic             tc_no
);
  logic all_ones;
  assign all_ones = &count_i;
  assign term_o   = all_ones & ~casc_en_ni;
  assign tc_no    = ~term_o;
endmodule

// File: rtl/rc_next_sel.sv
module rc_next_sel
  import rc_pkg::*;
(
  input  logic    load_i,
  input  logic    cnt_en_ni,
  input  logic    casc_en_ni,
  input  logic    reload_mode_i,
  input  logic    term_i,
  output rc_act_e act_o
);
  always_comb begin
    if (load_i)                          act_o = ACT_LOAD;
    else if (cnt_en_ni || casc_en_ni)    act_o = ACT_HOLD;
    else if (reload_mode_i && term_i)    act_o = ACT_RELOAD;
    else                                 act_o = ACT_INC;
  end
endmodule

// File: rtl/rc_state_reg.sv
module rc_state_reg
  import rc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rc_act_e          act_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             div_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      div_o   <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_LOAD, ACT_RELOAD: count_o <= preset_i;
        ACT_INC:              count_o <= count_o + ONE;
        default:              count_o <= count_o;
      endcase
      div_o <= (act_i == ACT_RELOAD);
    end
  end
endmodule

// File: rtl/reload_counter.sv
module reload_counter
  import rc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             cnt_en_ni,
  input  logic             casc_en_ni,
  input  logic             reload_mode_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_no,
  output logic             div_o
);
  rc_act_e act;
  logic    term;

  rc_term_detect #(.WIDTH(WIDTH)) u_term (
    .count_i    (count_o),
    .casc_en_ni (casc_en_ni),
    .term_o     (term),
    .tc_no      (tc_no)
  );

  rc_next_sel u_sel (
    .load_i        (load_i),
    .cnt_en_ni     (cnt_en_ni),
    .casc_en_ni    (casc_en_ni),
    .reload_mode_i (reload_mode_i),
    .term_i        (term),
    .act_o         (act)
  );

  rc_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act),
    .preset_i (preset_i),
    .count_o  (count_o),
    .div_o    (div_o)
  );

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(preset_i)) && !div_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (cnt_en_ni || casc_en_ni)) |=> $stable(count_o) && !div_o); // R3
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_ni && !casc_en_ni && !(reload_mode_i && !tc_no))
      |=> count_o == WIDTH'($past(count_o) + WIDTH'(1))); // R5
  AST_RELOAD_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_ni && reload_mode_i && !tc_no)
      |=> (count_o == $past(preset_i)) && div_o); // R6
  AST_DIV_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> $past(!load_i && !cnt_en_ni && reload_mode_i && !tc_no)); // R7
endmodule

// File: tb/reload_counter_test.sv
module reload_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [7:0] pre_lo = 8'd0, pre_hi = 8'd0;
  logic en_n = 1'b1, casc_n = 1'b1, mode = 1'b0;
  logic [7:0] cnt_lo, cnt_hi;
  logic tc_lo_n, tc_hi_n, div_lo, div_hi;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_lo = 0, m_hi = 0;
  bit m_div_lo = 0, m_div_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .preset_i(pre_lo),
    .cnt_en_ni(en_n), .casc_en_ni(casc_n), .reload_mode_i(mode),
    .count_o(cnt_lo), .tc_no(tc_lo_n), .div_o(div_lo));

  // upper stage of the R8 chain
  reload_counter uut_hi (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .preset_i(pre_hi),
    .cnt_en_ni(1'b0), .casc_en_ni(tc_lo_n), .reload_mode_i(1'b0),
    .count_o(cnt_hi), .tc_no(tc_hi_n), .div_o(div_hi));

  function automatic int nxt(int c, bit ld, int p, bit en, bit cs, bit md);
    if (ld) return p;
    if (en || cs) return c;
    if (md && c == 255) return p;
    return (c + 1) % 256;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_div_lo = 0; m_div_hi = 0;
    end else begin
      automatic bit lo_tc_n = !(m_lo == 255 && !casc_n);
      automatic int n_lo = nxt(m_lo, load, pre_lo, en_n, casc_n, mode);
      automatic int n_hi = nxt(m_hi, load, pre_hi, 1'b0, lo_tc_n, 1'b0);
      m_div_lo = !load && !en_n && !casc_n && mode && m_lo == 255;
      m_div_hi = 0;
      m_lo = n_lo; m_hi = n_hi;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R1 R3 R4 R5 R6 R7 R8)
  always @(negedge clk) if (!done) begin
    chk("R3 R5 R6 count_lo", cnt_lo, m_lo);
    chk("R4 tc_lo", tc_lo_n, !(m_lo == 255 && !casc_n));
    chk("R7 div_lo", div_lo, m_div_lo);
    chk("R8 count_hi", cnt_hi, m_hi);
    chk("R4 tc_hi", tc_hi_n, !(m_hi == 255 && !(m_lo == 255 && !casc_n)));
    chk("R7 div_hi", div_hi, m_div_hi);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic measure(int p);
    int gap;
    load = 1; pre_lo = 8'(p); step(1);
    load = 0; mode = 1; en_n = 0; casc_n = 0;
    @(negedge clk); while (!div_lo) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!div_lo) begin @(negedge clk); gap++; end
    chk("R7 divide ratio", gap, 256 - p);
    @(posedge clk); #2;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WD_LIMIT);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    step(2);
    chk("R1 reset count", cnt_lo, 0);
    chk("R1 reset tc", tc_lo_n, 1);
    chk("R1 reset div", div_lo, 0);
    rst_n = 1; step(1);

    // R2: load with enables inactive
    load = 1; pre_lo = 8'hA5; pre_hi = 8'h00; step(1);
    load = 0; step(1);
    chk("R2 load", cnt_lo, 8'hA5);
    // R3: each enable alone blocks counting
    en_n = 0; casc_n = 1; step(3);
    chk("R3 hold casc", cnt_lo, 8'hA5);
    en_n = 1; casc_n = 0; step(3);
    chk("R3 hold en", cnt_lo, 8'hA5);
    // R5: continuous wrap
    en_n = 0; load = 1; pre_lo = 8'hFC; step(1);
    load = 0; step(3);
    chk("R4 tc at 255", tc_lo_n, 0);
    casc_n = 1; #1;
    chk("R4 tc follows casc", tc_lo_n, 1);
    casc_n = 0; step(1);
    chk("R5 wrap to 0", cnt_lo, 0);
    step(300);

    // R6 R7: reload mode divide ratios
    measure(8'hF0);
    measure(8'hFA);
    measure(8'h80);
    mode = 0;

    // R8: two-stage chain forms a 16-bit count
    load = 1; pre_lo = 8'hFE; pre_hi = 8'h12; step(1);
    load = 0; step(3);
    chk("R8 chain value", {cnt_hi, cnt_lo}, 16'h1301);
    step(600);

    // R1: reset mid-cycle
    #1 rst_n = 0; #1;
    chk("R1 async clear", cnt_lo, 0);
    chk("R1 async clear hi", cnt_hi, 0);
    step(2);
    rst_n = 1; step(2);
    summary();
  end
endmodule